// File: doc/BRIEF.md
# DRAM Page-Mode Access Controller

This block sits between a simple CPU-side request/ready port and an external 16-bit DRAM device. For each access it splits the linear byte address into a row part and a column part. It presents both parts on one multiplexed address bus and sequences the row strobe, two byte-lane column strobes, the write strobe and the output-enable strobe. The CPU holds a request together with its address, write data, byte enables and direction until ready is returned. Read data is valid on the cycle that ready is high.

When page mode is enabled, the controller keeps the row open after an access completes. If the CPU presents another request in the cycle right after ready, and that request targets the same row, only a short column phase is run and the row strobe stays low. A row miss or an idle cycle closes the page: the row strobe goes high for one precharge state. A configuration code selects how many byte-address bits form the column. That choice also sets which bits take part in the row-hit comparison. A second configuration field adds wait states to every column phase.

Top module: `dram_fpc`

## Requirements
- R1: A full access runs four states with no wait states: a row state (RAS high, row address on the bus), a RAS-low state with the row address held, a column state (column address, CAS high), and a final state with the enabled CAS strobes low and ready high. From idle, ready is seen four clocks after the request is first sampled.
- R2: With page mode on (cfg_burst_i=1), a request presented in the cycle after ready that hits the open row keeps RAS low. It drives the column address at once and completes in a two-state column phase, so ready comes two clocks after the previous ready.
- R3: With cfg_burst_i=0, every access is a full access preceded by one precharge state, even when the row matches.
- R4: A chained request that misses the open row gets one precharge state with RAS high and then a full access. Ready comes five clocks after the previous ready.
- R5: Code cfg_shift_i=c selects a column width of cb = 8+c bits for c=0..2, and cb = 11 for c=3..7. The column on ma_o is byte-address bits [cb:1], and the row is bits [cb+13:cb+1].
- R6: The row-hit comparison uses all address bits above bit cb. Addresses that differ only in bits cb..0 hit, and any difference above bit cb misses.
- R7: cfg_wait_i=w inserts w extra states with CAS low before the final state, in both full and page-hit accesses. CAS is low for w+1 states per access.
- R8: ucas_n_o is low during the CAS states only when be_i[1]=1 (data bits 15:8). lcas_n_o is low only when be_i[0]=1 (bits 7:0).
- R9: In a write, we_n_o is low, dq_oe_o is high and dq_o equals wdata_i throughout the column phase, and oe_n_o stays high.
- R10: In a read, oe_n_o is low during the column phase, we_n_o and dq_oe_o are inactive, and rdata_o equals dq_i while ready is high.
- R11: After reset, and after any cycle following ready with no request, RAS, both CAS strobes, WE and OE are high and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 1 = upper lane |
| ready_o | output | 1 | Access completes this cycle |
| rdata_o | output | 16 | Read data, valid with ready |
| cfg_burst_i | input | 1 | Page-mode enable |
| cfg_shift_i | input | 3 | Column width code |
| cfg_wait_i | input | 2 | Wait states per column phase |
| ras_n_o | output | 1 | Row strobe, active low |
| ucas_n_o | output | 1 | Upper-lane column strobe, active low |
| lcas_n_o | output | 1 | Lower-lane column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| oe_n_o | output | 1 | Output enable, active low |
| ma_o | output | 13 | Multiplexed row/column address |
| dq_o | output | 16 | Data driven to DRAM |
| dq_oe_o | output | 1 | Data driver enable |
| dq_i | input | 16 | Data from DRAM |

## Verification
The assertions assume that the CPU holds request, address, direction and byte enables steady from the request until ready. They also assume that the configuration inputs change only while ready is high or while no page is open. The RAS-fall address check and the page-mode closing check depend on these assumptions. The bench changes inputs only at the falling edge of a ready cycle or while idle, and it waits two idle clocks before it alters the column width. Every access it issues has at least one byte enable set.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_RAS, S_COL, S_WAIT, S_CAS, S_OPEN
  } dram_state_e;

  // column width selected by the shift code, clamped at the last step
  function automatic int unsigned col_bits(input logic [2:0] code,
                                           input int unsigned min_cb,
                                           input int unsigned steps);
    int unsigned c;
    c = int'(code);
    if (c > steps - 1) c = steps - 1;
    return min_cb + c;
  endfunction
endpackage

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned MUX_W  = 13,
  parameter int unsigned MIN_CB = 8,
  parameter int unsigned STEPS  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        shift_i,
  output logic [MUX_W-1:0]  row_ma_o,
  output logic [MUX_W-1:0]  col_ma_o,
  output logic [ADDR_W-1:0] row_key_o
);
  int unsigned cb;
  logic [ADDR_W-1:0] col_mask;

  always_comb begin
    cb        = dram_pkg::col_bits(shift_i, MIN_CB, STEPS);
    col_mask  = ~({ADDR_W{1'b1}} << cb);
    row_key_o = addr_i >> (cb + 1);
    row_ma_o  = MUX_W'(row_key_o);
    col_ma_o  = MUX_W'((addr_i >> 1) & col_mask);
  end
endmodule

// File: rtl/dram_page_tracker.sv
module dram_page_tracker #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] key_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] open_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_row_q <= '0;
    else if (load_i) open_row_q <= key_i;
  end

  assign hit_o = (key_i == open_row_q);
endmodule

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int unsigned WAIT_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               burst_i,
  input  logic               hit_i,
  input  logic [WAIT_W-1:0]  wait_i,
  output dram_pkg::dram_state_e state_o,
  output logic               hit_go_o
);
  import dram_pkg::*;

  dram_state_e st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;

  // open page reused as the column-address state of the next access
  assign hit_go_o = (st_q == S_OPEN) && req_i && burst_i && hit_i;
  assign state_o  = st_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: if (req_i) st_d = S_ROW;
      S_ROW:  st_d = S_RAS;
      S_RAS:  st_d = S_COL;
      S_COL: begin
        if (wait_i != '0) begin st_d = S_WAIT; cnt_d = wait_i; end
        else st_d = S_CAS;
      end
      S_WAIT: begin
        cnt_d = cnt_q - WAIT_W'(1);
        if (cnt_q == WAIT_W'(1)) st_d = S_CAS;
      end
      S_CAS:  st_d = S_OPEN;
      S_OPEN: begin
        if (hit_go_o) begin
          if (wait_i != '0) begin st_d = S_WAIT; cnt_d = wait_i; end
          else st_d = S_CAS;
        end else if (req_i) st_d = S_ROW;  // this state was the precharge
        else st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dram_fpc.sv
module dram_fpc #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MUX_W  = 13,
  parameter int unsigned MIN_CB = 8,
  parameter int unsigned STEPS  = 4,
  parameter int unsigned WAIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cfg_burst_i,
  input  logic [2:0]        cfg_shift_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  output logic              ras_n_o,
  output logic              ucas_n_o,
  output logic              lcas_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [MUX_W-1:0]  ma_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  import dram_pkg::*;
  localparam int unsigned LANES = 2;

  dram_state_e       state;
  logic              hit, hit_go;
  logic [MUX_W-1:0]  row_ma, col_ma;
  logic [ADDR_W-1:0] row_key;
  logic              col_phase, cas_act, ras_act;
  logic [LANES-1:0]  cas_n;

  dram_addr_mux #(.ADDR_W(ADDR_W), .MUX_W(MUX_W), .MIN_CB(MIN_CB), .STEPS(STEPS)) u_mux (
    .addr_i(addr_i), .shift_i(cfg_shift_i),
    .row_ma_o(row_ma), .col_ma_o(col_ma), .row_key_o(row_key));

  dram_page_tracker #(.ADDR_W(ADDR_W)) u_page (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(state == S_RAS),
    .key_i(row_key), .hit_o(hit));

  dram_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .burst_i(cfg_burst_i),
    .hit_i(hit), .wait_i(cfg_wait_i), .state_o(state), .hit_go_o(hit_go));

  assign col_phase = (state == S_COL) || (state == S_WAIT) || (state == S_CAS) || hit_go;
  assign cas_act   = (state == S_WAIT) || (state == S_CAS);
  assign ras_act   = (state == S_RAS) || col_phase;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cas_n[l] = !(cas_act && be_i[l]);
  end

  assign ras_n_o  = !ras_act;
  assign lcas_n_o = cas_n[0];
  assign ucas_n_o = cas_n[1];
  assign ma_o     = col_phase ? col_ma : row_ma;
  assign we_n_o   = !(col_phase && we_i);
  assign oe_n_o   = !(col_phase && !we_i);
  assign dq_oe_o  = col_phase && we_i;
  assign dq_o     = wdata_i;
  assign ready_o  = (state == S_CAS);
  assign rdata_o  = dq_i;
endmodule

// File: rtl/dram_fpc_chk.sv
module dram_fpc_chk #(
  parameter int unsigned MUX_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             ras_n_o,
  input logic             ucas_n_o,
  input logic             lcas_n_o,
  input logic             we_n_o,
  input logic             oe_n_o,
  input logic             dq_oe_o,
  input logic [MUX_W-1:0] ma_o,
  input logic             cfg_burst_i
);
  p_row_held_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(ras_n_o)) |-> (ma_o == $past(ma_o)));

  p_ready_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_ready_in_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !ras_n_o);

  p_no_page_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !cfg_burst_i) |=> ras_n_o);

  p_cas_under_ras_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ucas_n_o || !lcas_n_o) |-> !ras_n_o);

  p_we_oe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_n_o && !oe_n_o));

  p_drive_on_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !we_n_o);
endmodule

bind dram_fpc dram_fpc_chk #(.MUX_W(MUX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .ras_n_o(ras_n_o),
  .ucas_n_o(ucas_n_o), .lcas_n_o(lcas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
  .dq_oe_o(dq_oe_o), .ma_o(ma_o), .cfg_burst_i(cfg_burst_i));

// File: tb/tb_dram_fpc.sv
module tb_dram_fpc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, burst = 1'b1;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = 2'b11, wt = '0;
  logic [2:0]  shift = 3'd3;
  logic ready, ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [12:0] ma;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign dq_i = addr[15:0] ^ 16'hA5A5;

  dram_fpc dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata),
    .cfg_burst_i(burst), .cfg_shift_i(shift), .cfg_wait_i(wt),
    .ras_n_o(ras_n), .ucas_n_o(ucas_n), .lcas_n_o(lcas_n), .we_n_o(we_n),
    .oe_n_o(oe_n), .ma_o(ma), .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i));

  typedef struct packed {
    logic keep; logic wr; logic [23:0] a; logic [1:0] be; logic [15:0] wd;
    logic bst; logic [2:0] sh; logic [1:0] w; logic hit;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 24'h012344, 2'b11, 16'h0000, 1'b1, 3'd3, 2'd0, 1'b0},
    '{1'b1, 1'b0, 24'h012346, 2'b11, 16'h0000, 1'b1, 3'd3, 2'd0, 1'b1},
    '{1'b1, 1'b1, 24'h012ABC, 2'b10, 16'hBEEF, 1'b1, 3'd3, 2'd0, 1'b1},
    '{1'b1, 1'b1, 24'h013000, 2'b01, 16'h1234, 1'b1, 3'd3, 2'd0, 1'b0},
    '{1'b1, 1'b0, 24'h013FFE, 2'b11, 16'h0000, 1'b1, 3'd3, 2'd2, 1'b1},
    '{1'b0, 1'b0, 24'h020000, 2'b11, 16'h0000, 1'b1, 3'd3, 2'd1, 1'b0},
    '{1'b1, 1'b0, 24'h020002, 2'b11, 16'h0000, 1'b1, 3'd3, 2'd0, 1'b0},
    '{1'b1, 1'b0, 24'h020004, 2'b11, 16'h0000, 1'b0, 3'd3, 2'd0, 1'b0},
    '{1'b0, 1'b1, 24'h020006, 2'b11, 16'h5A5A, 1'b0, 3'd3, 2'd0, 1'b0},
    '{1'b1, 1'b0, 24'h000200, 2'b11, 16'h0000, 1'b1, 3'd0, 2'd0, 1'b0},
    '{1'b1, 1'b0, 24'h0003FE, 2'b10, 16'h0000, 1'b1, 3'd0, 2'd0, 1'b1},
    '{1'b0, 1'b0, 24'h000400, 2'b01, 16'h0000, 1'b1, 3'd0, 2'd0, 1'b0},
    '{1'b1, 1'b0, 24'h000FFE, 2'b11, 16'h0000, 1'b1, 3'd6, 2'd0, 1'b0},
    '{1'b0, 1'b1, 24'h000402, 2'b11, 16'h0F0F, 1'b1, 3'd6, 2'd1, 1'b1}
  };

  function automatic int cbits(input logic [2:0] c);
    return (c >= 3'd3) ? 11 : 8 + int'(c);
  endfunction
  function automatic logic [12:0] exp_row(input logic [23:0] a, input logic [2:0] c);
    logic [23:0] t;
    t = a >> (cbits(c) + 1);
    return t[12:0];
  endfunction
  function automatic logic [12:0] exp_col(input logic [23:0] a, input logic [2:0] c);
    logic [23:0] t;
    t = (a >> 1) & ((24'd1 << cbits(c)) - 24'd1);
    return t[12:0];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  bit chained = 1'b0;

  task automatic run_vec(input vec_t v);
    int lat, cas_cnt, ras_hi, exp_lat, base;
    logic ras_s [16];
    logic [12:0] ma_s [16];
    string tag;
    req = 1'b1; we = v.wr; addr = v.a; be = v.be; wdata = v.wd;
    burst = v.bst; shift = v.sh; wt = v.w;
    lat = 0; cas_cnt = 0; ras_hi = 0;
    do begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (lat < 16) begin ras_s[lat] = ras_n; ma_s[lat] = ma; end
      if (!ucas_n || !lcas_n) cas_cnt++;
      if (ras_n) ras_hi++;
    end while (!ready && lat < 20);
    base = chained ? 1 : 0;
    if (v.hit && v.bst && chained) begin
      exp_lat = 2 + int'(v.w);
      chk(lat == exp_lat, "R2", "page-hit latency", lat, exp_lat);
      chk(ras_hi == 0, "R2", "RAS stayed low", ras_hi, 0);
      chk(ma_s[1] == exp_col(v.a, v.sh), "R5", "column on open page", ma_s[1], exp_col(v.a, v.sh));
    end else begin
      exp_lat = 4 + int'(v.w) + base;
      tag = !v.bst ? "R3" : (v.sh == 3'd0) ? "R6" : chained ? "R4" : "R1";
      chk(lat == exp_lat, tag, "full latency", lat, exp_lat);
      chk(ras_hi == 1 + base, tag, "RAS high states", ras_hi, 1 + base);
      chk(ras_s[base+1] && ma_s[base+1] == exp_row(v.a, v.sh), "R1", "row state",
          ma_s[base+1], exp_row(v.a, v.sh));
      chk(!ras_s[base+2] && ma_s[base+2] == exp_row(v.a, v.sh), "R1", "row held at RAS fall",
          ma_s[base+2], exp_row(v.a, v.sh));
    end
    chk(cas_cnt == int'(v.w) + 1, "R7", "CAS-low states", cas_cnt, int'(v.w) + 1);
    chk(ma == exp_col(v.a, v.sh), "R5", "column at ready", ma, exp_col(v.a, v.sh));
    chk({ucas_n, lcas_n} == ~v.be, "R8", "lane strobes", {ucas_n, lcas_n}, ~v.be);
    if (v.wr) begin
      chk(!we_n && oe_n && dq_oe && dq_o == v.wd, "R9", "write drive",
          {we_n, oe_n, dq_oe, dq_o}, {1'b0, 1'b1, 1'b1, v.wd});
    end else begin
      chk(!oe_n && we_n && !dq_oe && rdata == (v.a[15:0] ^ 16'hA5A5), "R10", "read data",
          rdata, v.a[15:0] ^ 16'hA5A5);
    end
    if (v.keep) chained = 1'b1;
    else begin
      req = 1'b0;
      chained = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(ras_n && ucas_n && lcas_n && !ready, "R11", "page closed when idle",
          {ras_n, ucas_n, lcas_n, ready}, 4'b1110);
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && ucas_n && lcas_n && we_n && oe_n && !ready && !dq_oe, "R11", "in reset",
        {ras_n, ucas_n, lcas_n, we_n, oe_n, ready, dq_oe}, 7'b1111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ras_n && ucas_n && lcas_n && we_n && oe_n && !ready, "R11", "after reset",
        {ras_n, ucas_n, lcas_n, we_n, oe_n, ready}, 6'b111110);
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    repeat (5) @(negedge clk);
    chk(ras_n && ucas_n && lcas_n && we_n && oe_n && !ready, "R11", "long idle",
        {ras_n, ucas_n, lcas_n, we_n, oe_n, ready}, 6'b111110);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule